// File: doc/BRIEF.md
# Thread-Partitioned LRU Victim Selector

This block chooses the replacement way for a set-associative L1 data cache that two hardware threads share. One thread is the primary and the other is the secondary. A runtime partition mode splits the ways between them. The primary thread always owns a contiguous run of ways starting at way 0, and the secondary thread owns the remaining ways.

A lookup may hit in any way, whichever thread owns it. On a miss, the block returns the least-recently-used way among the ways owned by the requesting thread. It then promotes that way as the refilled line in the same access.

Recency is kept per set as a complete age ordering of all ways. Age 0 marks the most recently used way and the highest age marks the least recently used one. The ordering is updated in one cycle on every hit and on every allocating miss. The mode can change between any two accesses. Lines are never flushed on a mode change. A line left in a way that has moved to the other thread stays valid until that thread evicts it.

Top module: `way_part_lru`

## Requirements
- R1: After reset, every set orders its ways by index: way 0 is the most recently used and way NUM_WAYS-1 is the least recently used.
- R2: Mode m from 0 to 5 gives the primary thread ways 0 to NUM_WAYS-1-m and gives the secondary thread every higher way. Any mode code above 5 behaves as mode 5.
- R3: For an access with acc_thread=0 (primary), acc_valid=1 and acc_hit=0, victim_way is the least recently used way among the primary ways.
- R4: For an access with acc_thread=1 (secondary), acc_valid=1 and acc_hit=0, victim_way is the least recently used way among the secondary ways.
- R5: A valid hit, or a valid miss that allocates, makes the touched way the most recently used in that set. The touched way is the hit way or the victim. The relative order of all other ways in the set is kept.
- R6: A hit in a way owned by the other thread is accepted and promotes that way like any other hit.
- R7: In mode 0, a valid miss by the secondary thread drives no_alloc=1, and the set's recency order does not change. no_alloc is 0 for every other access.
- R8: While acc_valid=0, no recency state changes.
- R9: A mode change applies to the next access without clearing any recency state.
- R10: Each set keeps its own recency order, and an access to one set leaves the other sets unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_set | input | SET_W | Set index of the access |
| acc_thread | input | 1 | Requesting thread: 0 for primary, 1 for secondary |
| acc_hit | input | 1 | 1 for a hit, 0 for a miss |
| acc_hit_way | input | WAY_W | Way that hit; used only when acc_hit=1 |
| part_mode | input | MODE_W | Partition mode |
| victim_way | output | WAY_W | Way to replace for a miss, valid in the same cycle |
| no_alloc | output | 1 | The miss cannot allocate because the requester owns no ways |

## Verification
The bench uses the default build: 8 ways, 16 sets and a 3-bit mode field. At that size a short hit-and-miss sequence can be traced by hand through the full 8-entry recency order.

The 3-bit mode field can also carry codes 6 and 7, which exercises the clamp to mode 5. Sixteen sets are enough to interleave two sets and show that they are independent.

Mode 0 and mode 1 reach the edge partitions: the secondary thread owns no ways in mode 0 and exactly one way in mode 1. Cross-thread hits and mode switches are placed mid-sequence, so later victims depend on the recency order being preserved.

// File: rtl/way_part_pkg.sv
package way_part_pkg;
    typedef enum logic {
        THR_PRIMARY   = 1'b0,
        THR_SECONDARY = 1'b1
    } thread_e;

    // Highest mode code with its own split; larger codes clamp to it.
    localparam int unsigned TOP_MODE = 5;
endpackage

// File: rtl/part_mask.sv
module part_mask
    import way_part_pkg::*;
#(
    parameter int unsigned NUM_WAYS = 8,
    parameter int unsigned MODE_W   = 3,
    parameter int unsigned MAX_MODE = TOP_MODE
) (
    input  logic [MODE_W-1:0]   mode,
    input  thread_e             thread,
    output logic [NUM_WAYS-1:0] owned
);
    localparam int unsigned CNT_W = $clog2(NUM_WAYS + 1);

    logic [MODE_W-1:0] eff_mode;
    logic [CNT_W-1:0]  pri_cnt;

    always_comb begin
        eff_mode = (mode > MODE_W'(MAX_MODE)) ? MODE_W'(MAX_MODE) : mode;
        pri_cnt  = CNT_W'(NUM_WAYS) - CNT_W'(eff_mode);
    end

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        logic is_pri;
        assign is_pri   = (CNT_W'(w) < pri_cnt);
        assign owned[w] = (thread == THR_SECONDARY) ? !is_pri : is_pri;
    end
endmodule

// File: rtl/lru_victim_pick.sv
module lru_victim_pick #(
    parameter int unsigned NUM_WAYS = 8,
    localparam int unsigned WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS-1:0][WAY_W-1:0] ages,
    input  logic [NUM_WAYS-1:0]            cand,
    output logic [WAY_W-1:0]               victim,
    output logic                           none
);
    logic [WAY_W-1:0] best_age;
    logic             found;

    always_comb begin
        victim   = '0;
        best_age = '0;
        found    = 1'b0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (cand[w] && (!found || ages[w] > best_age)) begin
                victim   = WAY_W'(w);
                best_age = ages[w];
                found    = 1'b1;
            end
        end
        none = !found;
    end
endmodule

// File: rtl/lru_age_update.sv
module lru_age_update #(
    parameter int unsigned NUM_WAYS = 8,
    localparam int unsigned WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS-1:0][WAY_W-1:0] ages_in,
    input  logic                           touch,
    input  logic [WAY_W-1:0]               touch_way,
    output logic [NUM_WAYS-1:0][WAY_W-1:0] ages_out
);
    logic [WAY_W-1:0] ref_age;
    assign ref_age = ages_in[touch_way];

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_age
        always_comb begin
            if (!touch)
                ages_out[w] = ages_in[w];
            else if (touch_way == WAY_W'(w))
                ages_out[w] = '0;
            else if (ages_in[w] < ref_age)
                ages_out[w] = ages_in[w] + 1'b1;
            else
                ages_out[w] = ages_in[w];
        end
    end
endmodule

// File: rtl/way_part_lru.sv
module way_part_lru
    import way_part_pkg::*;
#(
    parameter int unsigned NUM_WAYS = 8,
    parameter int unsigned NUM_SETS = 16,
    parameter int unsigned MODE_W   = 3,
    localparam int unsigned WAY_W   = $clog2(NUM_WAYS),
    localparam int unsigned SET_W   = $clog2(NUM_SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [SET_W-1:0]  acc_set,
    input  logic              acc_thread,
    input  logic              acc_hit,
    input  logic [WAY_W-1:0]  acc_hit_way,
    input  logic [MODE_W-1:0] part_mode,
    output logic [WAY_W-1:0]  victim_way,
    output logic              no_alloc
);
    typedef logic [NUM_WAYS-1:0][WAY_W-1:0] set_ages_t;
    typedef struct packed {
        set_ages_t [NUM_SETS-1:0] ages;
    } state_t;

    state_t              st_d, st_q;
    set_ages_t           cur_ages, new_ages;
    logic [NUM_WAYS-1:0] owner_mask;
    logic                no_owned;
    logic                do_touch;
    logic [WAY_W-1:0]    touch_way;

    assign cur_ages = st_q.ages[acc_set];

    part_mask #(.NUM_WAYS(NUM_WAYS), .MODE_W(MODE_W), .MAX_MODE(TOP_MODE)) u_mask (
        .mode   (part_mode),
        .thread (thread_e'(acc_thread)),
        .owned  (owner_mask)
    );

    lru_victim_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
        .ages   (cur_ages),
        .cand   (owner_mask),
        .victim (victim_way),
        .none   (no_owned)
    );

    always_comb begin
        no_alloc  = acc_valid && !acc_hit && no_owned;
        do_touch  = acc_valid && (acc_hit || !no_owned);
        touch_way = acc_hit ? acc_hit_way : victim_way;
    end

    lru_age_update #(.NUM_WAYS(NUM_WAYS)) u_upd (
        .ages_in   (cur_ages),
        .touch     (do_touch),
        .touch_way (touch_way),
        .ages_out  (new_ages)
    );

    always_comb begin
        st_d = st_q;
        st_d.ages[acc_set] = new_ages;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++)
                for (int w = 0; w < NUM_WAYS; w++)
                    st_q.ages[s][w] <= WAY_W'(w);
        end else begin
            st_q <= st_d;
        end
    end

    // Allocating misses stay inside the requester's partition.
    assert_victim_owned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_hit && !no_alloc) |-> owner_mask[victim_way]);

    // Only a secondary miss in mode 0 may refuse allocation.
    assert_noalloc_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        no_alloc |-> (acc_thread && part_mode == '0));

    assert_noalloc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        no_alloc |=> (st_q == $past(st_q)));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (st_q == $past(st_q)));

    assert_touch_mru_R5: assert property (@(posedge clk) disable iff (!rst_n)
        do_touch |=> (st_q.ages[$past(acc_set)][$past(touch_way)] == '0));
endmodule

// File: tb/way_part_lru_test.sv
module way_part_lru_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 16;

    // Entry: {mode[3], set[4], thread[1], hit[1], way[3], exp_victim[3], exp_noalloc[1]}
    localparam logic [15:0] VECS [0:NV-1] = '{
        {3'd0, 4'd0, 1'b0, 1'b0, 3'd0, 3'd7, 1'b0}, // R3 reset order
        {3'd0, 4'd0, 1'b0, 1'b0, 3'd0, 3'd6, 1'b0}, // R5 refill promoted
        {3'd0, 4'd0, 1'b1, 1'b0, 3'd0, 3'd0, 1'b1}, // R7 no ways
        {3'd0, 4'd0, 1'b0, 1'b1, 3'd5, 3'd0, 1'b0}, // R5 hit way 5
        {3'd0, 4'd0, 1'b0, 1'b0, 3'd0, 3'd4, 1'b0}, // R7 state kept
        {3'd2, 4'd0, 1'b0, 1'b0, 3'd0, 3'd3, 1'b0}, // R9 switch to mode 2
        {3'd2, 4'd0, 1'b1, 1'b0, 3'd0, 3'd7, 1'b0}, // R4
        {3'd2, 4'd0, 1'b1, 1'b0, 3'd0, 3'd6, 1'b0}, // R4
        {3'd2, 4'd0, 1'b1, 1'b1, 3'd2, 3'd0, 1'b0}, // R6 cross-thread hit
        {3'd2, 4'd0, 1'b0, 1'b0, 3'd0, 3'd1, 1'b0}, // R6 effect visible
        {3'd5, 4'd1, 1'b0, 1'b0, 3'd0, 3'd2, 1'b0}, // R10 fresh set
        {3'd5, 4'd1, 1'b1, 1'b0, 3'd0, 3'd7, 1'b0}, // R4
        {3'd5, 4'd0, 1'b1, 1'b0, 3'd0, 3'd5, 1'b0}, // R9
        {3'd1, 4'd0, 1'b1, 1'b0, 3'd0, 3'd7, 1'b0}, // R2 single way
        {3'd1, 4'd0, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0}, // R3
        {3'd7, 4'd1, 1'b0, 1'b0, 3'd0, 3'd1, 1'b0}  // R2 clamp
    };

    function automatic string vec_tag(int i);
        case (i)
            0, 14:     return "R3";
            1, 3:      return "R5";
            2, 4:      return "R7";
            5, 12:     return "R9";
            6, 7, 11:  return "R4";
            8, 9:      return "R6";
            10:        return "R10";
            default:   return "R2";
        endcase
    endfunction

    logic       clk = 1'b0;
    logic       rst_n;
    logic       acc_valid, acc_thread, acc_hit;
    logic [3:0] acc_set;
    logic [2:0] acc_hit_way, part_mode, victim_way;
    logic       no_alloc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    way_part_lru uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
        .acc_thread(acc_thread), .acc_hit(acc_hit), .acc_hit_way(acc_hit_way),
        .part_mode(part_mode), .victim_way(victim_way), .no_alloc(no_alloc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive(logic v, logic [2:0] m, logic [3:0] s, logic t, logic h, logic [2:0] w);
        acc_valid = v; part_mode = m; acc_set = s;
        acc_thread = t; acc_hit = h; acc_hit_way = w;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: got 1 expected 0");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        drive(1'b0, 3'd0, 4'd0, 1'b0, 1'b0, 3'd0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset ordering seen on an untouched set
        drive(1'b1, 3'd0, 4'd3, 1'b0, 1'b0, 3'd0);
        #1;
        chk("R1 reset victim", int'(victim_way), 7);
        chk("R1 reset no_alloc", int'(no_alloc), 0);
        step();

        for (int i = 0; i < NV; i++) begin
            logic [15:0] e;
            e = VECS[i];
            drive(1'b1, e[15:13], e[12:9], e[8], e[7], e[6:4]);
            #1;
            if (!e[7]) begin
                chk(vec_tag(i), int'(no_alloc), int'(e[0]));
                if (!e[0]) chk(vec_tag(i), int'(victim_way), int'(e[3:1]));
            end
            step();
        end

        // R8: idle cycle with a hit on way 6 of set 1 must not promote it
        drive(1'b0, 3'd0, 4'd1, 1'b0, 1'b1, 3'd6);
        #1;
        chk("R8 idle no_alloc", int'(no_alloc), 0);
        step();
        drive(1'b1, 3'd0, 4'd1, 1'b0, 1'b0, 3'd0);
        #1;
        chk("R8 idle ignored", int'(victim_way), 6);
        step();

        // R1: reset in mid-run restores index ordering in a used set
        rst_n = 1'b0;
        drive(1'b0, 3'd0, 4'd0, 1'b0, 1'b0, 3'd0);
        step();
        rst_n = 1'b1;
        drive(1'b1, 3'd0, 4'd0, 1'b0, 1'b0, 3'd0);
        #1;
        chk("R1 re-reset victim", int'(victim_way), 7);
        step();

        finish_run();
    end
endmodule